// File: doc/BRIEF.md
# Byte-Wide Programmable Read-Only Memory with Strobed Programming

This block is a synthesizable model of a one-time-style programmable byte store. In normal operation it behaves as a read-only memory: an address and an active-low chip select bring the addressed byte onto a byte output with an output-enable flag that stands in for a tri-state driver. The depth is 2^ADDR_W words; a 13-bit address gives the common 8192-byte arrangement.

A separate programming mode, selected by one `prog_mode` input, reuses the address pins. A latch strobe captures the upper address bits from the lowest address pins. Two active-low strobes, one for programming and one for verifying, then either burn a byte into the addressed word, drive the word back for comparison, or leave the data pins released. Programming can only clear bits. An erase input, and reset, walk every word back to all ones. A parameter selects a power-switched variant that reports standby whenever the part is deselected in read mode.

All decoding and writes are synchronous to one clock. The storage is a single array with one synchronous read and one write port, so it maps onto block RAM.

Top module: `fuse_prom`

## Requirements
- R1: In read mode (`prog_mode`=0) with `cs_n`=0, the byte stored at `addr` appears on `data_out` with `data_oe`=1 two clock edges after the pins are applied.
- R2: In read mode with `cs_n`=1, `data_oe` is 0 and `data_out` is all zeros two edges later.
- R3: In programming mode, a high `latch` at an edge captures `addr[HI_W-1:0]` (HI_W = ADDR_W-LOW_W) as the upper word-address bits. The lower bits come straight from `addr[LOW_W-1:0]`, and `addr[ADDR_W-1:LOW_W]` is ignored.
- R4: In programming mode, a falling `pgm_n` while `vfy_n`=1 writes the addressed word. The fall is `pgm_n` high at one edge and low at the next. The new word is the old word ANDed with `data_in`.
- R5: Programming never sets a bit: programming a word with all ones, or with ones where it already holds zeros, leaves it unchanged.
- R6: In programming mode with `pgm_n`=1 and `vfy_n`=0, the addressed byte appears on `data_out` with `data_oe`=1 two edges later.
- R7: In programming mode with both strobes high, `data_oe` is 0 and `data_out` is zero two edges later.
- R8: With both strobes low in programming mode, `illegal` is 1 one edge later, no word is written, and `data_oe` is 0.
- R9: Reset and a pulse on `erase` start a sweep that sets every word to all ones. `erasing` is high for exactly 2^ADDR_W edges, and no data is driven during the sweep. A blank check afterwards reads all ones.
- R10: With POWER_SWITCHED=1, `powered_down` is 1 one edge after read mode with `cs_n`=1, and is 0 otherwise. With POWER_SWITCHED=0 it stays 0.
- R11: In read mode, `pgm_n` and `vfy_n` have no effect: a `pgm_n` fall does not change any stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts an erase sweep |
| prog_mode | input | 1 | 1 selects programming mode |
| cs_n | input | 1 | Active-low chip select (read mode) |
| addr | input | ADDR_W | Address pins; low bits shared with upper-bit latch in programming mode |
| latch | input | 1 | Upper-address capture strobe (programming mode) |
| pgm_n | input | 1 | Active-low program strobe |
| vfy_n | input | 1 | Active-low verify strobe |
| erase | input | 1 | Starts an erase sweep |
| data_in | input | DATA_W | Byte to program |
| data_out | output | DATA_W | Read or verify byte, zero when not driven |
| data_oe | output | 1 | Output driver enable |
| illegal | output | 1 | Both strobes low in programming mode |
| erasing | output | 1 | Erase sweep in progress |
| powered_down | output | 1 | Standby indicator of the power-switched variant |

## Verification
The bench builds the block with ADDR_W=10, LOW_W=6 and DATA_W=8. A 1024-word array can then be swept completely with blank checks, programmed, reprogrammed and read back both through the latch-based programming path and through plain reads. The four latched upper bits sit on pins that also carry low address bits, so every combination of latched and direct bits is exercised. A second instance with POWER_SWITCHED=0 shares the stimulus to cover the non-switched variant.

// File: rtl/fuse_prom_pkg.sv
package fuse_prom_pkg;

  typedef enum logic [2:0] {
    MD_READ,
    MD_DESELECT,
    MD_PROGRAM,
    MD_VERIFY,
    MD_INHIBIT,
    MD_ILLEGAL
  } prom_mode_e;

endpackage

// File: rtl/fuse_prom_mode_dec.sv
module fuse_prom_mode_dec
  import fuse_prom_pkg::*;
(
  input  logic       prog_mode,
  input  logic       cs_n,
  input  logic       pgm_n,
  input  logic       vfy_n,
  output prom_mode_e mode
);

  always_comb begin
    if (!prog_mode) begin
      mode = cs_n ? MD_DESELECT : MD_READ;
    end else begin
      unique case ({pgm_n, vfy_n})
        2'b01:   mode = MD_PROGRAM;
        2'b10:   mode = MD_VERIFY;
        2'b11:   mode = MD_INHIBIT;
        default: mode = MD_ILLEGAL;
      endcase
    end
  end

endmodule

// File: rtl/fuse_prom_addr_mux.sv
module fuse_prom_addr_mux #(
  parameter int ADDR_W = 12,
  parameter int LOW_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_mode,
  input  logic              latch,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] addr_eff
);

  localparam int HI_W = ADDR_W - LOW_W;

  logic [HI_W-1:0] hi_q;

  // Upper word-address bits arrive on the lowest pins while latch is high.
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
    end else if (prog_mode && latch) begin
      hi_q <= addr[HI_W-1:0];
    end
  end

  assign addr_eff = prog_mode ? {hi_q, addr[LOW_W-1:0]} : addr;

  assert_latch_capture_R3: assert property (@(posedge clk) disable iff (rst)
    (prog_mode && latch) |=> (addr_eff[ADDR_W-1:LOW_W] == $past(addr[HI_W-1:0])) || !prog_mode);

  assert_latch_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!latch && prog_mode) |=> $stable(hi_q));

endmodule

// File: rtl/fuse_prom_array.sv
module fuse_prom_array #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // One write port and one registered read port, read-first.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/fuse_prom_erase_seq.sv
module fuse_prom_erase_seq #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              erase,
  output logic              busy,
  output logic [ADDR_W-1:0] idx
);

  localparam logic [ADDR_W-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      idx <= idx + 1'b1;
      if (idx == LAST) begin
        busy <= 1'b0;
      end
    end else if (erase) begin
      busy <= 1'b1;
      idx  <= '0;
    end
  end

  assert_sweep_ends_last_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(idx) == LAST));

  assert_sweep_starts_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && erase) |=> (busy && idx == '0));

endmodule

// File: rtl/fuse_prom.sv
module fuse_prom
  import fuse_prom_pkg::*;
#(
  parameter int ADDR_W         = 12,
  parameter int LOW_W          = 8,
  parameter int DATA_W         = 8,
  parameter bit POWER_SWITCHED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_mode,
  input  logic              cs_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              latch,
  input  logic              pgm_n,
  input  logic              vfy_n,
  input  logic              erase,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              illegal,
  output logic              erasing,
  output logic              powered_down
);

  prom_mode_e        mode_c;
  logic [ADDR_W-1:0] addr_eff;
  logic [ADDR_W-1:0] sweep_idx;
  logic [DATA_W-1:0] rd_q;
  logic              pgm_prev_q;
  logic              pgm_fall;
  logic              wr_pend_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;
  logic              arr_wr_en;
  logic [ADDR_W-1:0] arr_wr_addr;
  logic [DATA_W-1:0] arr_wr_data;
  logic              oe_s1_q;

  fuse_prom_mode_dec u_mode_dec (
    .prog_mode (prog_mode),
    .cs_n      (cs_n),
    .pgm_n     (pgm_n),
    .vfy_n     (vfy_n),
    .mode      (mode_c)
  );

  fuse_prom_addr_mux #(
    .ADDR_W (ADDR_W),
    .LOW_W  (LOW_W)
  ) u_addr_mux (
    .clk       (clk),
    .rst       (rst),
    .prog_mode (prog_mode),
    .latch     (latch),
    .addr      (addr),
    .addr_eff  (addr_eff)
  );

  fuse_prom_erase_seq #(
    .ADDR_W (ADDR_W)
  ) u_erase_seq (
    .clk   (clk),
    .rst   (rst),
    .erase (erase),
    .busy  (erasing),
    .idx   (sweep_idx)
  );

  // Program strobe edge: high at the previous edge, low now, verify released.
  assign pgm_fall = (mode_c == MD_PROGRAM) && pgm_prev_q && !erasing;

  always_ff @(posedge clk) begin
    if (rst) begin
      pgm_prev_q <= 1'b1;
      wr_pend_q  <= 1'b0;
    end else begin
      pgm_prev_q <= pgm_n;
      wr_pend_q  <= pgm_fall;
    end
  end

  always_ff @(posedge clk) begin
    if (pgm_fall) begin
      wr_addr_q <= addr_eff;
      wr_data_q <= data_in;
    end
  end

  // The sweep owns the write port; a pending program merges with the word
  // fetched on the strobe edge so bits can only be cleared.
  always_comb begin
    arr_wr_en   = erasing || wr_pend_q;
    arr_wr_addr = erasing ? sweep_idx : wr_addr_q;
    arr_wr_data = erasing ? {DATA_W{1'b1}} : (rd_q & wr_data_q);
  end

  fuse_prom_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_array (
    .clk     (clk),
    .rd_addr (addr_eff),
    .rd_data (rd_q),
    .wr_en   (arr_wr_en),
    .wr_addr (arr_wr_addr),
    .wr_data (arr_wr_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_s1_q  <= 1'b0;
      illegal  <= 1'b0;
      data_oe  <= 1'b0;
      data_out <= '0;
    end else begin
      oe_s1_q  <= !erasing && ((mode_c == MD_READ) || (mode_c == MD_VERIFY));
      illegal  <= (mode_c == MD_ILLEGAL);
      data_oe  <= oe_s1_q;
      data_out <= oe_s1_q ? rd_q : '0;
    end
  end

  generate
    if (POWER_SWITCHED) begin : g_pwr_sw
      logic pd_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          pd_q <= 1'b0;
        end else begin
          pd_q <= (mode_c == MD_DESELECT);
        end
      end
      assign powered_down = pd_q;
    end else begin : g_always_on
      assign powered_down = 1'b0;
    end
  endgenerate

  assert_standby_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    powered_down |=> !data_oe);

  assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    illegal |=> !data_oe);

  assert_illegal_no_write_R8: assert property (@(posedge clk) disable iff (rst)
    wr_pend_q |-> !illegal);

  assert_write_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    wr_pend_q |-> ($past(prog_mode) && !$past(pgm_n) && $past(vfy_n)));

  assert_sweep_no_drive_R9: assert property (@(posedge clk) disable iff (rst)
    erasing |=> !oe_s1_q);

  assert_idle_out_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !data_oe |-> (data_out == '0));

endmodule

// File: tb/fuse_prom_bench.sv
module fuse_prom_bench;

  localparam int AW    = 10;
  localparam int LW    = 6;
  localparam int HW    = AW - LW;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          prog_mode = 1'b0;
  logic          cs_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          latch = 1'b0;
  logic          pgm_n = 1'b1;
  logic          vfy_n = 1'b1;
  logic          erase = 1'b0;
  logic [DW-1:0] data_in = '0;
  logic [DW-1:0] data_out, data_out_b;
  logic          data_oe, data_oe_b;
  logic          illegal, illegal_b;
  logic          erasing, erasing_b;
  logic          powered_down, powered_down_b;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [DW-1:0] exp_mem [DEPTH];

  always #2 clk = ~clk;

  fuse_prom #(.ADDR_W(AW), .LOW_W(LW), .DATA_W(DW), .POWER_SWITCHED(1'b1)) u_fuse_prom (
    .clk(clk), .rst(rst), .prog_mode(prog_mode), .cs_n(cs_n), .addr(addr),
    .latch(latch), .pgm_n(pgm_n), .vfy_n(vfy_n), .erase(erase), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .illegal(illegal), .erasing(erasing),
    .powered_down(powered_down));

  fuse_prom #(.ADDR_W(AW), .LOW_W(LW), .DATA_W(DW), .POWER_SWITCHED(1'b0)) u_fuse_prom_nopd (
    .clk(clk), .rst(rst), .prog_mode(prog_mode), .cs_n(cs_n), .addr(addr),
    .latch(latch), .pgm_n(pgm_n), .vfy_n(vfy_n), .erase(erase), .data_in(data_in),
    .data_out(data_out_b), .data_oe(data_oe_b), .illegal(illegal_b), .erasing(erasing_b),
    .powered_down(powered_down_b));

  task automatic chk(input int actual, input int expected, input string what);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, actual, expected);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_sweep();
    while (erasing) tick(1);
  endtask

  // Upper pins carry a fixed junk pattern; only addr[HW-1:0] should be latched.
  task automatic load_hi(input int a);
    prog_mode = 1'b1;
    addr  = AW'((42 << HW) | ((a >> LW) & ((1 << HW) - 1)));
    latch = 1'b1;
    tick(1);
    latch = 1'b0;
  endtask

  // Unused upper pins get the complement of the latched bits.
  task automatic put_low(input int a);
    addr = AW'(((~(a >> LW) & ((1 << HW) - 1)) << LW) | (a & ((1 << LW) - 1)));
  endtask

  task automatic program_word(input int a, input logic [DW-1:0] d);
    load_hi(a);
    put_low(a);
    data_in = d;
    pgm_n = 1'b1;
    vfy_n = 1'b1;
    tick(1);
    pgm_n = 1'b0;
    tick(1);
    pgm_n = 1'b1;
    tick(1);
    exp_mem[a] = exp_mem[a] & d;
  endtask

  task automatic verify_word(input int a, input string tag);
    load_hi(a);
    put_low(a);
    pgm_n = 1'b1;
    vfy_n = 1'b0;
    tick(2);
    chk(int'(data_oe), 1, {tag, " verify oe"});
    chk(int'(data_out), int'(exp_mem[a]), $sformatf("%s verify word %0d", tag, a));
    vfy_n = 1'b1;
  endtask

  task automatic read_word(input int a, input string tag);
    prog_mode = 1'b0;
    cs_n = 1'b0;
    addr = AW'(a);
    tick(2);
    chk(int'(data_oe), 1, {tag, " read oe"});
    chk(int'(data_out), int'(exp_mem[a]), $sformatf("%s read word %0d", tag, a));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) exp_mem[a] = '1;
    tick(3);
    rst = 1'b0;
    // R9: reset starts a sweep with nothing driven
    chk(int'(erasing), 1, "R9 sweep after reset");
    chk(int'(data_oe), 0, "R9 no drive after reset");
    chk(int'(illegal), 0, "R8 illegal clear after reset");
    wait_sweep();

    // R9/R6: blank check through verify
    for (int a = 0; a < DEPTH; a++) verify_word(a, "R9 R6 blank");

    // R4/R3: program every word through the latched upper bits
    for (int a = 0; a < DEPTH; a++) program_word(a, DW'((a * 37 + 11) ^ (a >> 3)));
    for (int a = 0; a < DEPTH; a++) verify_word(a, "R4 R3 R6");
    for (int a = 0; a < DEPTH; a++) read_word(a, "R1");

    // R5: reprogramming can only clear bits
    for (int a = 0; a < DEPTH; a += 3) program_word(a, 8'hFF);
    for (int a = 1; a < DEPTH; a += 5) program_word(a, DW'(~a));
    for (int a = 0; a < DEPTH; a++) read_word(a, "R5");

    // R7: inhibit releases the data pins
    load_hi(77);
    put_low(77);
    pgm_n = 1'b1;
    vfy_n = 1'b1;
    tick(2);
    chk(int'(data_oe), 0, "R7 inhibit oe");
    chk(int'(data_out), 0, "R7 inhibit data");

    // R2/R10: deselected read
    prog_mode = 1'b0;
    cs_n = 1'b1;
    addr = AW'(12);
    tick(1);
    chk(int'(powered_down), 1, "R10 standby when deselected");
    chk(int'(powered_down_b), 0, "R10 always-on variant");
    tick(1);
    chk(int'(data_oe), 0, "R2 deselect oe");
    chk(int'(data_out), 0, "R2 deselect data");
    cs_n = 1'b0;
    tick(1);
    chk(int'(powered_down), 0, "R10 selected wakes");

    // R8: both strobes low
    load_hi(300);
    put_low(300);
    data_in = '0;
    pgm_n = 1'b1;
    vfy_n = 1'b0;
    tick(1);
    pgm_n = 1'b0;
    tick(1);
    chk(int'(illegal), 1, "R8 illegal flag");
    tick(1);
    chk(int'(data_oe), 0, "R8 no drive when illegal");
    pgm_n = 1'b1;
    tick(1);
    vfy_n = 1'b1;
    tick(1);
    chk(int'(illegal), 0, "R8 illegal clears");
    read_word(300, "R8 no write");

    // R11: strobes ignored in read mode
    prog_mode = 1'b0;
    cs_n = 1'b0;
    addr = AW'(513);
    data_in = '0;
    vfy_n = 1'b1;
    pgm_n = 1'b1;
    tick(1);
    pgm_n = 1'b0;
    tick(1);
    pgm_n = 1'b1;
    tick(1);
    read_word(513, "R11 read mode strobe");

    // R9: erase pulse, sweep length and blank result
    begin
      int n;
      erase = 1'b1;
      tick(1);
      erase = 1'b0;
      n = 0;
      while (erasing) begin
        n++;
        if (n == 5) begin
          chk(int'(data_oe), 0, "R9 no drive during sweep");
        end
        tick(1);
      end
      chk(n, DEPTH, "R9 sweep length");
    end
    for (int a = 0; a < DEPTH; a++) exp_mem[a] = '1;
    for (int a = 0; a < DEPTH; a++) read_word(a, "R9 erased");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule